// File: doc/BRIEF.md
# Keyboard and Display Character Interface

This block puts a keyboard and a character display on a processor bus as four byte-wide registers. The keyboard side hands over one byte per `key_valid` pulse. The byte is latched into the input data register, and the input-ready flag is raised. The display side takes bytes through a valid/ready stream. When software writes the output data register, the byte is offered on `disp_data` with `disp_valid` high. It stays there until the display raises `disp_ready`.

Software polls two flags in the status register, or uses interrupts:
- The input-ready flag goes low when software reads the input data register.
- The output-ready flag goes low when software writes the output data register. It comes back once the display has taken the byte and reports that it is ready.
- Two enable bits in the control register gate the flags into request bits in the status register. The OR of the two request bits drives the single `irq` pin.

Back-pressure rules:
- The keyboard stream has no ready signal and is never stalled. A byte that arrives while the previous one is unread replaces it.
- The display stream follows valid/ready. `disp_data` is held stable while `disp_valid` is high and `disp_ready` is low.
- Software must wait for the output-ready flag before writing again. A write made earlier replaces the byte that is still pending.

Top module: `kbd_disp_if`

## Requirements
- R1: While `rst` is high, `disp_valid`, `irq`, the status register and the control register are all 0. The first clock edge after reset release with `disp_ready` high sets the output-ready flag, so status reads 0x02.
- R2: A cycle with `key_valid` high latches `key_data` into the input data register (offset 0) and sets the input-ready flag (status bit 0) at that clock edge.
- R3: A bus read of offset 0 returns the latched byte and clears status bit 0 at the clock edge that ends the read. A bus write to offset 0 has no effect.
- R4: If a key arrives while status bit 0 is already set, or in the same cycle as a read of offset 0, the new byte replaces the old one and status bit 0 stays set.
- R5: A bus write to offset 1 clears the output-ready flag (status bit 1) and raises `disp_valid` with the written byte at that edge. While `disp_ready` is low, `disp_valid` and `disp_data` hold. A read of offset 1 returns the last written byte.
- R6: A clock edge with `disp_valid` and `disp_ready` both high drops `disp_valid`. The next edge with `disp_ready` high sets status bit 1.
- R7: The control register (offset 3) holds the display interrupt enable in bit 1 and the keyboard interrupt enable in bit 2. The other bits ignore writes and read 0.
- R8: Status bit 2 reads (bit 0 AND keyboard enable), and status bit 3 reads (bit 1 AND display enable). Status bits 7:4 read 0, and writes to offset 2 have no effect.
- R9: `irq` is high exactly when status bit 2 or status bit 3 is set.
- R10: Bytes pass through both paths unaltered, the carriage-return code 0x0D included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Bus access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from offset |
| key_valid | input | 1 | Keyboard byte strobe |
| key_data | input | 8 | Keyboard byte |
| disp_valid | output | 1 | Display byte offered |
| disp_data | output | 8 | Display byte |
| disp_ready | input | 1 | Display can accept a byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so a register value can be seen in the same cycle its offset is presented. Every flag, data register and stream output changes at the first clock edge after its cause. The one exception is the output-ready flag after a display handshake, which needs a second edge. The bench drives inputs at the falling edge and samples 1 ns later. It checks each result exactly one falling edge after the rising edge that is due to produce it. Status and control are looked at without a clock edge, so looking does not disturb the flags.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_KEYBYTE  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DISPBYTE = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_FLAGS    = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_ENABLES  = 2'd3;
  localparam int FLAG_KEY_RDY  = 0;
  localparam int FLAG_DISP_RDY = 1;
  localparam int FLAG_KEY_REQ  = 2;
  localparam int FLAG_DISP_REQ = 3;
  localparam int EN_DISP       = 1;
  localparam int EN_KEY        = 2;
endpackage

// File: rtl/kdi_key_in.sv
module kdi_key_in #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_data,
  input  logic              rd_take,
  output logic [DATA_W-1:0] byte_q,
  output logic              have_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      have_q <= 1'b0;
    end else if (key_valid) begin
      byte_q <= key_data;
      have_q <= 1'b1;
    end else if (rd_take) begin
      have_q <= 1'b0;
    end
  end

  assert_key_sets_R2: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> have_q);
  assert_key_wins_R4: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> byte_q == $past(key_data));
  assert_take_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !key_valid) |=> !have_q);
endmodule

// File: rtl/kdi_disp_out.sv
module kdi_disp_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_put,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_data,
  output logic              free_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_data  <= '0;
      free_q     <= 1'b0;
    end else if (wr_put) begin
      disp_valid <= 1'b1;
      disp_data  <= wr_data;
      free_q     <= 1'b0;
    end else begin
      if (disp_valid && disp_ready) disp_valid <= 1'b0;
      if (!disp_valid && disp_ready) free_q <= 1'b1;
    end
  end

  assert_put_clears_R5: assert property (@(posedge clk) disable iff (rst)
    wr_put |=> (!free_q && disp_valid));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready && !wr_put) |=> (disp_valid && $stable(disp_data)));
  assert_no_free_pending_R6: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> !free_q);
endmodule

// File: rtl/kdi_regs.sv
module kdi_regs
  import kdi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] key_byte,
  input  logic              key_have,
  input  logic [DATA_W-1:0] disp_byte,
  input  logic              disp_free,
  output logic              rd_take,
  output logic              wr_put,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] EN_MASK =
    (DATA_W'(1) << EN_DISP) | (DATA_W'(1) << EN_KEY);

  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] flags;
  logic              key_req, disp_req;

  assign rd_take = cpu_sel && !cpu_we && (cpu_addr == OFS_KEYBYTE);
  assign wr_put  = cpu_sel &&  cpu_we && (cpu_addr == OFS_DISPBYTE);

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (cpu_sel && cpu_we && cpu_addr == OFS_ENABLES)
      en_q <= cpu_wdata & EN_MASK;
  end

  assign key_req  = key_have  && en_q[EN_KEY];
  assign disp_req = disp_free && en_q[EN_DISP];

  always_comb begin
    flags = '0;
    flags[FLAG_KEY_RDY]  = key_have;
    flags[FLAG_DISP_RDY] = disp_free;
    flags[FLAG_KEY_REQ]  = key_req;
    flags[FLAG_DISP_REQ] = disp_req;
  end

  always_comb begin
    case (cpu_addr)
      OFS_KEYBYTE:  cpu_rdata = key_byte;
      OFS_DISPBYTE: cpu_rdata = disp_byte;
      OFS_FLAGS:    cpu_rdata = flags;
      default:      cpu_rdata = en_q;
    endcase
  end

  assign irq = key_req || disp_req;

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!key_have && !disp_free) |-> !irq);
  assert_en_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~EN_MASK) == '0);
endmodule

// File: rtl/kbd_disp_if.sv
module kbd_disp_if
  import kdi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_sel,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic [DATA_W-1:0]     cpu_rdata,
  input  logic                  key_valid,
  input  logic [DATA_W-1:0]     key_data,
  output logic                  disp_valid,
  output logic [DATA_W-1:0]     disp_data,
  input  logic                  disp_ready,
  output logic                  irq
);
  logic              rd_take, wr_put, key_have, disp_free;
  logic [DATA_W-1:0] key_byte;

  kdi_key_in #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_data(key_data),
    .rd_take(rd_take), .byte_q(key_byte), .have_q(key_have));

  kdi_disp_out #(.DATA_W(DATA_W)) u_disp (
    .clk(clk), .rst(rst), .wr_put(wr_put), .wr_data(cpu_wdata),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_data(disp_data),
    .free_q(disp_free));

  kdi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .key_byte(key_byte),
    .key_have(key_have), .disp_byte(disp_data), .disp_free(disp_free),
    .rd_take(rd_take), .wr_put(wr_put), .cpu_rdata(cpu_rdata), .irq(irq));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!disp_valid && !irq));
endmodule

// File: tb/tb_kbd_disp_if.sv
`timescale 1ns/1ps
module tb_kbd_disp_if;
  logic clk = 0, rst = 1;
  logic cpu_sel = 0, cpu_we = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, key_data = 0;
  logic key_valid = 0, disp_ready = 1;
  logic [7:0] cpu_rdata, disp_data;
  logic disp_valid, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_disp_if dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    cpu_sel = 1; cpu_we = 0; cpu_addr = a; #1; d = cpu_rdata; cpu_sel = 0;
  endtask

  task automatic rd_edge(logic [1:0] a, output logic [7:0] d);
    cpu_sel = 1; cpu_we = 0; cpu_addr = a; #1; d = cpu_rdata;
    tick(); cpu_sel = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] v);
    cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
    tick(); cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic key(logic [7:0] v);
    key_valid = 1; key_data = v; tick(); key_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(2, d); chk("R1 status in reset", d, 8'h00);
    peek(3, d); chk("R1 control in reset", d, 8'h00);
    chk("R1 disp_valid in reset", {7'd0, disp_valid}, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst = 0; tick();
    peek(2, d); chk("R1 output ready after reset", d, 8'h02);
  endtask

  task automatic t_key_read();
    logic [7:0] d;
    key(8'h0D);
    peek(2, d); chk("R2 key sets bit0", d, 8'h03);
    wr(0, 8'h55);
    rd_edge(0, d); chk("R10 R3 CR byte unaltered, write ignored", d, 8'h0D);
    peek(2, d); chk("R3 read clears bit0", d, 8'h02);
  endtask

  task automatic t_overwrite();
    logic [7:0] d;
    key(8'h61); key(8'h62);
    peek(2, d); chk("R4 bit0 stays set", d, 8'h03);
    peek(0, d); chk("R4 overwrite", d, 8'h62);
    cpu_sel = 1; cpu_we = 0; cpu_addr = 0; key_valid = 1; key_data = 8'h63;
    tick(); cpu_sel = 0; key_valid = 0;
    peek(2, d); chk("R4 same-cycle key keeps bit0", d, 8'h03);
    rd_edge(0, d); chk("R4 same-cycle key byte", d, 8'h63);
  endtask

  task automatic t_display();
    logic [7:0] d;
    disp_ready = 0;
    wr(1, 8'h0D);
    chk("R5 valid raised", {7'd0, disp_valid}, 8'h01);
    chk("R10 R5 display byte", disp_data, 8'h0D);
    peek(2, d); chk("R5 write clears bit1", d, 8'h00);
    repeat (3) tick();
    chk("R5 valid held", {7'd0, disp_valid}, 8'h01);
    chk("R5 data held", disp_data, 8'h0D);
    peek(1, d); chk("R5 readback", d, 8'h0D);
    disp_ready = 1; tick();
    chk("R6 valid drops", {7'd0, disp_valid}, 8'h00);
    peek(2, d); chk("R6 bit1 not yet set", d, 8'h00);
    tick();
    peek(2, d); chk("R6 bit1 set", d, 8'h02);
  endtask

  task automatic t_control();
    logic [7:0] d;
    wr(3, 8'hFF);
    peek(3, d); chk("R7 only bits 1,2 kept", d, 8'h06);
    peek(2, d); chk("R8 display request", d, 8'h0A);
    chk("R9 irq from display", {7'd0, irq}, 8'h01);
    wr(2, 8'hFF);
    peek(2, d); chk("R8 status write ignored", d, 8'h0A);
    wr(3, 8'h04);
    peek(2, d); chk("R8 display request gated", d, 8'h02);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
    key(8'h41);
    peek(2, d); chk("R8 keyboard request", d, 8'h07);
    chk("R9 irq from keyboard", {7'd0, irq}, 8'h01);
    rd_edge(0, d);
    chk("R9 irq drops after read", {7'd0, irq}, 8'h00);
    wr(3, 8'h00);
    key(8'h42);
    chk("R9 disabled key no irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    int n = 0;
    while (!done && n < 20000) begin @(posedge clk); n++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    t_reset();
    t_key_read();
    t_overwrite();
    t_display();
    t_control();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule